// File: doc/BRIEF.md
# Mode-Configurable Modulo Phase Accumulator

This block produces the 32-bit phase stream for a polar-to-rectangular converter. It is used for direct waveform synthesis and for frequency or phase modulation. The phase word is in units of pi radians. The top bit weighs plus or minus pi, the next bit pi/2, and so on down to pi times 2^-31. All arithmetic wraps modulo 2^32, so one wrap is one full turn.

A 32-bit input word is captured into an input register, but only while a load enable is high. A 2-bit mode input is registered on every edge. It decides what the captured word does:

- It can be passed on as a coarse phase.
- It can be added once to the running phase as an offset.
- It can be added to the running phase on every clock as a frequency step.
- It can do both of the last two.

A synchronous clear puts the running phase back to zero so that a synthesized waveform starts from a known angle.

Top module: `mod_phase_accum`

## Requirements
- R1: While `rst_n` is low at a rising edge, all internal registers and `phase_out` become zero.
- R2: With registered mode 00, `phase_out` equals the upper 16 bits of the registered word followed by 16 zero bits. The low 16 input bits and the running phase have no effect on it.
- R3: The input word register loads `phase_in` only at edges where `load_en` is 1. Otherwise it keeps its value, and `phase_in` has no effect on later results.
- R4: With registered mode bit 1 set (frequency mode), the running phase grows by the registered word at every edge, modulo 2^32. `phase_out` shows the updated running phase at that same edge.
- R5: `clear` high at an edge zeroes the running phase, taking priority over any increment.
- R6: With registered mode bit 1 clear, the running phase holds its value. With registered mode 01 (offset mode), `phase_out` equals the running phase plus the registered word, and the offset does not accumulate.
- R7: With registered mode 11, `phase_out` equals the updated running phase plus the registered word, modulo 2^32.
- R8: The `mode` input is registered at every edge, independent of `load_en`. A mode change therefore acts from the edge after the one that captures it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_en | input | 1 | Clock enable of the input word register |
| clear | input | 1 | Synchronous zeroing of the running phase |
| mode | input | 2 | Bit 1: frequency accumulation, bit 0: phase offset; 00 pass-through |
| phase_in | input | 32 | Frequency step / phase offset / coarse phase word |
| phase_out | output | 32 | Registered phase, units of pi radians, modulo 2^32 |

## Verification
The assertions assume that `mode`, `clear` and `load_en` are known (0 or 1) at every rising edge after reset. They also assume that overflow past 2^32 is intended wrap-around rather than an error. The bench drives all inputs only after a rising edge has settled and never leaves any of them undriven. It deliberately feeds step values such as 0x8000_0000, 0xC000_0000 and all-ones, so that the wrap is exercised within those assumptions. Words presented while `load_en` is low are the complement of the loaded word, so that any leak through the input register would show at the output.

// File: rtl/mod_phase_accum_pkg.sv
// Package: shared widths and mode encoding for the modulo phase accumulator.
// Assumes: mode bit 1 enables frequency accumulation, bit 0 enables offset.
package mod_phase_accum_pkg;

    localparam int unsigned PHASE_W  = 32;
    localparam int unsigned COARSE_W = 16;

    typedef enum logic [1:0] {
        PA_PASS = 2'b00,
        PA_OFFS = 2'b01,
        PA_FREQ = 2'b10,
        PA_BOTH = 2'b11
    } pa_mode_e;

    // True when the mode accumulates the word every clock.
    function automatic logic mode_accumulates(input logic [1:0] m);
        return m[1];
    endfunction

    // True when the mode adds the word once as an offset.
    function automatic logic mode_offsets(input logic [1:0] m);
        return m[0];
    endfunction

endpackage

// File: rtl/mod_phase_accum_inreg.sv
// Module: input capture stage.
// Holds the phase word under a clock enable and registers the mode on
// every edge. Assumes a synchronous active-low reset.
module mod_phase_accum_inreg #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_en,
    input  logic [W-1:0] word_d,
    input  logic [1:0]   mode_d,
    output logic [W-1:0] word_q,
    output logic [1:0]   mode_q
);

    // Word register: loads only while the enable is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (load_en) begin
            word_q <= word_d;
        end
    end

    // Mode register: follows the mode input on every edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= 2'b00;
        end else begin
            mode_q <= mode_d;
        end
    end

endmodule

// File: rtl/mod_phase_accum_integrator.sv
// Module: running-phase register.
// Adds the step every clock while step_en is high, with modulo 2^W wrap.
// Clear has priority over the step. Also exposes the next-state value
// so that the output stage can show the update of the same edge.
module mod_phase_accum_integrator #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         step_en,
    input  logic [W-1:0] step,
    output logic [W-1:0] acc_q,
    output logic [W-1:0] acc_next
);

    // Next-state selection: clear, step or hold.
    always_comb begin
        if (clear) begin
            acc_next = '0;
        end else if (step_en) begin
            acc_next = acc_q + step;
        end else begin
            acc_next = acc_q;
        end
    end

    // State register for the running phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_next;
        end
    end

endmodule

// File: rtl/mod_phase_accum_combiner.sv
// Module: output phase former.
// Pass mode gives the coarse part of the word with zero fine bits. Other
// modes give the running phase, plus the word when offset is enabled.
// The result is registered. Assumes COARSE_W <= W.
module mod_phase_accum_combiner #(
    parameter int unsigned W        = 32,
    parameter int unsigned COARSE_W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [1:0]   mode_q,
    input  logic [W-1:0] word_q,
    input  logic [W-1:0] acc_next,
    output logic [W-1:0] phase_q
);
    import mod_phase_accum_pkg::*;

    localparam int unsigned FINE_W = W - COARSE_W;

    logic [W-1:0] coarse_phase;
    logic [W-1:0] offset_term;
    logic [W-1:0] phase_d;

    // Coarse phase: upper bits kept, fine bits forced to zero.
    generate
        if (FINE_W == 0) begin : g_full
            assign coarse_phase = word_q;
        end else begin : g_split
            assign coarse_phase = {word_q[W-1 -: COARSE_W], {FINE_W{1'b0}}};
        end
    endgenerate

    // Offset term: the word when offset is enabled, else zero.
    assign offset_term = mode_offsets(mode_q) ? word_q : '0;

    // Output selection by registered mode.
    always_comb begin
        if (pa_mode_e'(mode_q) == PA_PASS) begin
            phase_d = coarse_phase;
        end else begin
            phase_d = acc_next + offset_term;
        end
    end

    // Output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_d;
        end
    end

endmodule

// File: rtl/mod_phase_accum.sv
// Module: mode-configurable modulo phase accumulator (top).
// Captures a phase word under load_en and registers the mode every edge.
// Accumulates and/or offsets the word and delivers a registered phase in
// units of pi radians, modulo 2^W. Assumes a synchronous active-low reset.
module mod_phase_accum #(
    parameter int unsigned W        = mod_phase_accum_pkg::PHASE_W,
    parameter int unsigned COARSE_W = mod_phase_accum_pkg::COARSE_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_en,
    input  logic         clear,
    input  logic [1:0]   mode,
    input  logic [W-1:0] phase_in,
    output logic [W-1:0] phase_out
);
    import mod_phase_accum_pkg::*;

    logic [W-1:0] word_q;
    logic [1:0]   mode_q;
    logic [W-1:0] acc_q;
    logic [W-1:0] acc_next;
    logic         step_en;

    // Frequency accumulation is enabled by the registered mode.
    assign step_en = mode_accumulates(mode_q);

    mod_phase_accum_inreg #(.W(W)) inreg_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_en (load_en),
        .word_d  (phase_in),
        .mode_d  (mode),
        .word_q  (word_q),
        .mode_q  (mode_q)
    );

    mod_phase_accum_integrator #(.W(W)) integ_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (clear),
        .step_en  (step_en),
        .step     (word_q),
        .acc_q    (acc_q),
        .acc_next (acc_next)
    );

    mod_phase_accum_combiner #(.W(W), .COARSE_W(COARSE_W)) comb_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_q   (mode_q),
        .word_q   (word_q),
        .acc_next (acc_next),
        .phase_q  (phase_out)
    );

endmodule

// File: rtl/mod_phase_accum_chk.sv
// Checker: temporal properties of the phase accumulator, bound to the top.
// Assumes 32-bit phase and 16-bit coarse field (package defaults).
module mod_phase_accum_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        load_en,
    input logic        clear,
    input logic [31:0] phase_in,
    input logic [31:0] word_q,
    input logic [1:0]  mode_q,
    input logic [1:0]  mode,
    input logic [31:0] acc_q,
    input logic [31:0] phase_out
);

    // R3: without load enable the captured word keeps its value.
    a_r3_word_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en |=> word_q == $past(word_q));

    // R3: with load enable the captured word follows the input.
    a_r3_word_loads: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> word_q == $past(phase_in));

    // R5: clear leaves a zero running phase.
    a_r5_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> acc_q == 32'h0);

    // R4: frequency mode steps the running phase by the word.
    a_r4_freq_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && mode_q[1]) |=> acc_q == $past(acc_q) + $past(word_q));

    // R6: without frequency mode the running phase holds.
    a_r6_acc_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !mode_q[1]) |=> $stable(acc_q));

    // R2: pass mode leaves the fine bits of the output at zero.
    a_r2_fine_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == 2'b00) |=> phase_out[15:0] == 16'h0);

    // R8: the registered mode follows the mode input each edge.
    a_r8_mode_reg: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> mode_q == $past(mode));

endmodule

bind mod_phase_accum mod_phase_accum_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_en   (load_en),
    .clear     (clear),
    .phase_in  (phase_in),
    .word_q    (word_q),
    .mode_q    (mode_q),
    .mode      (mode),
    .acc_q     (acc_q),
    .phase_out (phase_out)
);

// File: tb/mod_phase_accum_tb_top.sv
// Bench: vector table walked by one loop, then directed tests.
module mod_phase_accum_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        load_en;
    logic        clear;
    logic [1:0]  mode;
    logic [31:0] phase_in;
    logic [31:0] phase_out;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    mod_phase_accum dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (load_en),
        .clear     (clear),
        .mode      (mode),
        .phase_in  (phase_in),
        .phase_out (phase_out)
    );

    // Fields: mode(2) | word(32) | run edges after clear(4) | expected(32)
    localparam int NV = 10;
    localparam logic [69:0] VEC [NV] = '{
        {2'b00, 32'h1234_ABCD, 4'd3, 32'h1234_0000},  // R2
        {2'b01, 32'h4000_0000, 4'd3, 32'h4000_0000},  // R6
        {2'b10, 32'h1000_0000, 4'd5, 32'h5000_0000},  // R4
        {2'b10, 32'h8000_0000, 4'd2, 32'h0000_0000},  // R4 wrap
        {2'b10, 32'hC000_0000, 4'd3, 32'h4000_0000},  // R4 wrap
        {2'b11, 32'h0100_0000, 4'd4, 32'h0500_0000},  // R7
        {2'b11, 32'hFFFF_FFFF, 4'd2, 32'hFFFF_FFFD},  // R7 wrap
        {2'b10, 32'h0000_0001, 4'd7, 32'h0000_0007},  // R4
        {2'b01, 32'hFFFF_0001, 4'd4, 32'hFFFF_0001},  // R6
        {2'b00, 32'h8000_FFFF, 4'd1, 32'h8000_0000}   // R2
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string rid, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: phase_out=%h expected=%h", rid, act, exp);
        end
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; load_en = 1'b1; clear = 1'b0;
        mode = 2'b10; phase_in = 32'hDEAD_BEEF;
        repeat (3) tick();
        check("R1 reset", phase_out, 32'h0);
        rst_n = 1'b1;

        // Table walk: clear + load, then run with complemented input (R3).
        for (int i = 0; i < NV; i++) begin
            clear = 1'b1; load_en = 1'b1;
            mode = VEC[i][69:68]; phase_in = VEC[i][67:36];
            tick();
            clear = 1'b0; load_en = 1'b0; phase_in = ~VEC[i][67:36];
            for (int k = 0; k < int'(VEC[i][35:32]); k++) tick();
            check($sformatf("R3/table row %0d", i), phase_out, VEC[i][31:0]);
        end

        // R3: step 0x100 loaded, then all-ones presented without load.
        clear = 1'b1; load_en = 1'b1; mode = 2'b10; phase_in = 32'h100;
        tick();
        clear = 1'b0; load_en = 1'b0; phase_in = 32'hFFFF_FFFF;
        repeat (3) tick();
        check("R3 load disabled", phase_out, 32'h300);

        // R5: clear mid-run zeroes, then stepping resumes from zero.
        clear = 1'b1;
        tick();
        check("R5 clear", phase_out, 32'h0);
        clear = 1'b0;
        tick();
        check("R5 resume", phase_out, 32'h100);

        // R8/R6: switch to offset mode; old mode applies for one edge.
        mode = 2'b01;
        tick();
        check("R8 mode delay", phase_out, 32'h200);
        tick();
        check("R6 offset", phase_out, 32'h300);
        tick();
        check("R6 no accumulate", phase_out, 32'h300);

        // R2: pass mode ignores the nonzero running phase.
        mode = 2'b00;
        repeat (2) tick();
        check("R2 acc ignored", phase_out, 32'h0);

        // R1: reset mid-run.
        mode = 2'b10; rst_n = 1'b0;
        tick();
        check("R1 reset mid-run", phase_out, 32'h0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule